// File: doc/BRIEF.md
# Paravirtual Device Control Register Block

This block is the register window that a guest driver sees for a simple paravirtual device. It sits on a small byte-addressed I/O bus that carries 8-, 16- and 32-bit accesses. Software learns the device's feature set through the window and acknowledges the features it will use. It selects one of several virtqueues, gives that queue a ring location as a page frame number, reads the queue's size, rings a doorbell and drives the device status byte. Interrupt causes collect in an 8-bit cause register. That register clears when it is read.

The device core attaches at the other side. It supplies its feature mask and ORs cause bits in through a set input. It receives the doorbell as a one-cycle kick pulse that carries a queue index. It also sees the acknowledged features, the status byte and the byte address of the selected ring. All register state is flopped. Read data appears on the cycle after the read strobe.

Top module: `pvdev_regs`

## Requirements
- R1: After reset the guest feature mask, queue selector, status byte, every ring frame number and the cause register are zero, and `irq_o` and `kick_o` are low.
- R2: A read of offset 0 returns `dev_features_i` with bit 24 (the notify-on-empty capability) forced to 1; writes to offset 0 are ignored.
- R3: Offset 4 holds the guest feature mask. A write stores it, a read returns it, and it drives `guest_features_o`.
- R4: A write to offset 14 updates the queue selector only when the written value is below `NUM_Q`. A larger value leaves the selector unchanged. A read of offset 14 returns the selector.
- R5: A write to offset 8 stores a frame number for the selected queue. A read of offset 8 returns the frame number of the selected queue. `qaddr_o` equals that frame number shifted left by 12.
- R6: A write to offset 8 never changes the queue selector.
- R7: A read of offset 12 returns the size table entry of the selected queue. The default sizes are 64, 128, 256 and 256 for queues 0 to 3.
- R8: A write to offset 16 raises `kick_o` for exactly one cycle, on the cycle after the write, with `kick_idx_o` equal to the written value. It stores nothing, and a read of offset 16 returns all ones.
- R9: A read of any offset other than 0, 4, 8, 12, 14, 18 and 19 returns all ones, masked to the access size.
- R10: A read of offset 19 returns the cause register and clears it in the same access. `irq_o` follows cause bit 0. Bits set through `isr_set_i` in the cycle of that read are kept.
- R11: A write to offset 18 stores the low 8 bits as the status byte. A write of zero also clears the guest features, the selector, every frame number and the cause register.
- R12: `bus_size` encodes the access as 0 for byte, 1 for 16-bit and 2 for 32-bit. Write data and read data are both masked to that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_size | input | 2 | Access width: 0 byte, 1 half, 2 word |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| dev_features_i | input | 32 | Feature mask offered by the device core |
| isr_set_i | input | 8 | Cause bits ORed into the cause register |
| guest_features_o | output | 32 | Acknowledged feature mask |
| dev_status_o | output | 8 | Device status byte |
| qaddr_o | output | 44 | Byte address of the selected queue's ring |
| kick_o | output | 1 | One-cycle doorbell pulse |
| kick_idx_o | output | 16 | Queue index written to the doorbell |
| irq_o | output | 1 | Level interrupt, cause bit 0 |

## Verification
Every result comes out of a register. A write changes state on the first clock edge after the strobe, so a read issued in the next cycle already sees it. Read data is due on the cycle after the read strobe. The kick pulse and any change to `irq_o` appear one edge after the access that causes them. The scoreboard monitor pops an expected read value only on the falling edge after a read strobe has been registered. The direct checks of the kick, interrupt and address outputs sample one nanosecond after the edge that updates them. In the simultaneous set-and-read case, the bench expects the old cause value on the read and the new set bits in the cause register afterwards.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;

    localparam logic [4:0] OFF_HOSTF  = 5'd0;
    localparam logic [4:0] OFF_GUESTF = 5'd4;
    localparam logic [4:0] OFF_QPFN   = 5'd8;
    localparam logic [4:0] OFF_QSIZE  = 5'd12;
    localparam logic [4:0] OFF_QSEL   = 5'd14;
    localparam logic [4:0] OFF_QKICK  = 5'd16;
    localparam logic [4:0] OFF_STATUS = 5'd18;
    localparam logic [4:0] OFF_ISR    = 5'd19;

    localparam int PAGE_SHIFT = 12;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

    function automatic logic [31:0] acc_mask(input logic [1:0] sz);
        case (sz)
            ACC_BYTE: acc_mask = 32'h0000_00FF;
            ACC_HALF: acc_mask = 32'h0000_FFFF;
            default:  acc_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/pvdev_qtable.sv
module pvdev_qtable #(
    parameter int NUM_Q = 4,
    parameter int PFN_W = 32,
    localparam int SEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             clr,
    input  logic [SEL_W-1:0] rd_idx,
    output logic [PFN_W-1:0] rd_pfn
);

    logic [PFN_W-1:0] pfn_q [NUM_Q];

    for (genvar g = 0; g < NUM_Q; g++) begin : g_entry
        logic [PFN_W-1:0] pfn_d;

        always_comb begin
            pfn_d = pfn_q[g];
            if (clr)
                pfn_d = '0;
            else if (wr_en && (wr_idx == SEL_W'(g)))
                pfn_d = wr_pfn;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) pfn_q[g] <= '0;
            else        pfn_q[g] <= pfn_d;
        end
    end

    always_comb begin
        rd_pfn = '0;
        for (int i = 0; i < NUM_Q; i++)
            if (rd_idx == SEL_W'(i)) rd_pfn = pfn_q[i];
    end

    // R11: a device reset leaves no frame number behind
    a_r11_table_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> (rd_pfn == '0));

endmodule

// File: rtl/pvdev_isr.sv
module pvdev_isr #(
    parameter int ISR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ISR_W-1:0] set_i,
    input  logic             rd_clr,
    input  logic             dev_clr,
    output logic [ISR_W-1:0] isr_o,
    output logic             irq_o
);

    logic [ISR_W-1:0] isr_d, isr_q;

    always_comb begin
        isr_d = (rd_clr || dev_clr) ? '0 : isr_q;
        isr_d = isr_d | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    assign isr_o = isr_q;
    assign irq_o = isr_q[0];

    // R10: reading the cause register empties it when nothing new arrives
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (set_i == '0)) |=> (isr_o == '0 && !irq_o));

    // R10: cause bits set in any cycle, even a read cycle, are kept
    a_r10_set_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((isr_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/pvdev_regs.sv
module pvdev_regs #(
    parameter int NUM_Q = 4,
    parameter int PFN_W = 32,
    parameter int NOTIFY_BIT = 24,
    parameter logic [NUM_Q*16-1:0] QSIZE_TABLE = {16'd256, 16'd256, 16'd128, 16'd64},
    localparam int SEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int QADDR_W = PFN_W + pvdev_pkg::PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         bus_addr,
    input  logic [1:0]         bus_size,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [31:0]        dev_features_i,
    input  logic [7:0]         isr_set_i,
    output logic [31:0]        guest_features_o,
    output logic [7:0]         dev_status_o,
    output logic [QADDR_W-1:0] qaddr_o,
    output logic               kick_o,
    output logic [15:0]        kick_idx_o,
    output logic               irq_o
);

    import pvdev_pkg::*;

    typedef struct packed {
        logic [31:0]      guest;
        logic [SEL_W-1:0] sel;
        logic [7:0]       status;
        logic [31:0]      rdata;
        logic             kick;
        logic [15:0]      kick_idx;
    } regs_t;

    regs_t r_d, r_q;

    logic [31:0]      wval;
    logic [31:0]      rd_val;
    logic             wr_guest, wr_pfn, wr_qsel, wr_kick, wr_status;
    logic             dev_reset, isr_rd;
    logic [PFN_W-1:0] cur_pfn;
    logic [7:0]       isr_val;
    logic [15:0]      cur_qsize;

    assign wval      = bus_wdata & acc_mask(bus_size);
    assign wr_guest  = bus_wr && (bus_addr == OFF_GUESTF);
    assign wr_pfn    = bus_wr && (bus_addr == OFF_QPFN);
    assign wr_qsel   = bus_wr && (bus_addr == OFF_QSEL);
    assign wr_kick   = bus_wr && (bus_addr == OFF_QKICK);
    assign wr_status = bus_wr && (bus_addr == OFF_STATUS);
    assign dev_reset = wr_status && (wval[7:0] == 8'd0);
    assign isr_rd    = bus_rd && (bus_addr == OFF_ISR);

    always_comb begin
        cur_qsize = '0;
        for (int i = 0; i < NUM_Q; i++)
            if (r_q.sel == SEL_W'(i)) cur_qsize = QSIZE_TABLE[i*16 +: 16];
    end

    pvdev_qtable #(
        .NUM_Q (NUM_Q),
        .PFN_W (PFN_W)
    ) i_qtable (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_pfn),
        .wr_idx (r_q.sel),
        .wr_pfn (wval[PFN_W-1:0]),
        .clr    (dev_reset),
        .rd_idx (r_q.sel),
        .rd_pfn (cur_pfn)
    );

    pvdev_isr #(
        .ISR_W (8)
    ) i_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (isr_set_i),
        .rd_clr  (isr_rd),
        .dev_clr (dev_reset),
        .isr_o   (isr_val),
        .irq_o   (irq_o)
    );

    always_comb begin
        rd_val = 32'hFFFF_FFFF;
        case (bus_addr)
            OFF_HOSTF:  rd_val = dev_features_i | (32'd1 << NOTIFY_BIT);
            OFF_GUESTF: rd_val = r_q.guest;
            OFF_QPFN:   rd_val = 32'(cur_pfn);
            OFF_QSIZE:  rd_val = {16'd0, cur_qsize};
            OFF_QSEL:   rd_val = 32'(r_q.sel);
            OFF_STATUS: rd_val = {24'd0, r_q.status};
            OFF_ISR:    rd_val = {24'd0, isr_val};
            default:    rd_val = 32'hFFFF_FFFF;
        endcase
    end

    always_comb begin
        r_d = r_q;
        r_d.kick = 1'b0;
        if (wr_guest)
            r_d.guest = wval;
        if (wr_qsel && (wval < 32'(NUM_Q)))
            r_d.sel = wval[SEL_W-1:0];
        if (wr_kick) begin
            r_d.kick     = 1'b1;
            r_d.kick_idx = wval[15:0];
        end
        if (wr_status)
            r_d.status = wval[7:0];
        if (dev_reset) begin
            r_d.guest = '0;
            r_d.sel   = '0;
        end
        if (bus_rd)
            r_d.rdata = rd_val & acc_mask(bus_size);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata        = r_q.rdata;
    assign guest_features_o = r_q.guest;
    assign dev_status_o     = r_q.status;
    assign kick_o           = r_q.kick;
    assign kick_idx_o       = r_q.kick_idx;
    assign qaddr_o          = {cur_pfn, {PAGE_SHIFT{1'b0}}};

    // R4: an out-of-range selector write is dropped
    a_r4_reject_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_qsel && (wval >= 32'(NUM_Q))) |=> $stable(r_q.sel));

    // R6: frame number writes leave the selector alone
    a_r6_pfn_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_QPFN) |=> $stable(r_q.sel));

    // R8: a kick only follows a doorbell write
    a_r8_kick_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |-> $past(bus_wr && bus_addr == OFF_QKICK));

    // R11: a zero status write wipes features and selector
    a_r11_status_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_STATUS && (bus_wdata[7:0] == 8'd0))
        |=> (guest_features_o == 32'd0 && dev_status_o == 8'd0 && r_q.sel == '0));

endmodule

// File: tb/test_pvdev_regs.sv
`timescale 1ns/1ps
module test_pvdev_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] dev_features_i = 32'h0000_0005;
    logic [7:0]  isr_set_i = '0;
    logic [31:0] guest_features_o;
    logic [7:0]  dev_status_o;
    logic [43:0] qaddr_o;
    logic        kick_o;
    logic [15:0] kick_idx_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] exp_data [$];
    string       exp_tag  [$];
    logic        rd_pend = 1'b0;

    always #2 clk = ~clk;

    pvdev_regs i_pvdev_regs (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_addr         (bus_addr),
        .bus_size         (bus_size),
        .bus_wr           (bus_wr),
        .bus_rd           (bus_rd),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .dev_features_i   (dev_features_i),
        .isr_set_i        (isr_set_i),
        .guest_features_o (guest_features_o),
        .dev_status_o     (dev_status_o),
        .qaddr_o          (qaddr_o),
        .kick_o           (kick_o),
        .kick_idx_o       (kick_idx_o),
        .irq_o            (irq_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one bus cycle: inputs change 1 ns after a rising edge
    task automatic op(input logic wr, input logic rd, input logic [4:0] a,
                      input logic [1:0] sz, input logic [31:0] d, input logic [7:0] set);
        @(posedge clk);
        #1;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_size = sz;
        bus_wdata = d; isr_set_i = set;
    endtask

    task automatic idle();
        op(1'b0, 1'b0, 5'd0, 2'd0, 32'd0, 8'd0);
    endtask

    task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
        op(1'b1, 1'b0, a, sz, d, 8'd0);
    endtask

    // driver: push the expected read value, then issue the read
    task automatic rd(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] e,
                      input string tag, input logic [7:0] set = 8'd0);
        exp_data.push_back(e);
        exp_tag.push_back(tag);
        op(1'b0, 1'b1, a, sz, 32'd0, set);
    endtask

    always @(posedge clk) rd_pend <= bus_rd;

    // monitor: read data is due on the edge after the strobe
    always @(negedge clk) begin
        if (rd_pend && rst_n) begin
            if (exp_data.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard unexpected read actual=%0h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_data.pop_front();
                t = exp_tag.pop_front();
                chk(t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();

        // R1 reset state
        chk("R1 irq", 64'(irq_o), 64'd0);
        chk("R1 kick", 64'(kick_o), 64'd0);
        chk("R1 guest out", 64'(guest_features_o), 64'd0);
        chk("R1 status out", 64'(dev_status_o), 64'd0);
        rd(5'd18, 2'd0, 32'h0, "R1 status read");
        rd(5'd14, 2'd1, 32'h0, "R1 selector read");
        rd(5'd19, 2'd0, 32'h0, "R1 cause read");
        rd(5'd8,  2'd2, 32'h0, "R1 frame read");

        // R2 host features with notify bit forced; R12 read width
        rd(5'd0, 2'd2, 32'h0100_0005, "R2 host features word");
        rd(5'd0, 2'd0, 32'h0000_0005, "R12 host features byte");
        rd(5'd0, 2'd1, 32'h0000_0005, "R12 host features half");
        wr(5'd0, 2'd2, 32'h0000_FFFF);
        rd(5'd0, 2'd2, 32'h0100_0005, "R2 host features ignore write");

        // R3 guest features, R12 write width
        wr(5'd4, 2'd2, 32'hA5A5_0F0F);
        idle();
        chk("R3 guest out", 64'(guest_features_o), 64'hA5A5_0F0F);
        rd(5'd4, 2'd2, 32'hA5A5_0F0F, "R3 guest read");
        wr(5'd4, 2'd0, 32'h1234_5678);
        rd(5'd4, 2'd2, 32'h0000_0078, "R12 byte write masked");

        // R4 selector range
        wr(5'd14, 2'd1, 32'd2);
        rd(5'd14, 2'd1, 32'd2, "R4 selector accepted");
        wr(5'd14, 2'd1, 32'd7);
        rd(5'd14, 2'd1, 32'd2, "R4 selector reject 7");
        wr(5'd14, 2'd2, 32'h0001_0001);
        rd(5'd14, 2'd1, 32'd2, "R4 selector reject wide");

        // R5 frame numbers, R6 selector kept
        wr(5'd8, 2'd2, 32'h0001_2345);
        rd(5'd14, 2'd1, 32'd2, "R6 selector after frame write");
        rd(5'd8, 2'd2, 32'h0001_2345, "R5 frame q2");
        idle();
        chk("R5 ring address q2", 64'(qaddr_o), 64'h0_1234_5000);
        wr(5'd14, 2'd1, 32'd1);
        wr(5'd8, 2'd2, 32'h0000_0777);
        rd(5'd8, 2'd2, 32'h0000_0777, "R5 frame q1");
        idle();
        chk("R5 ring address q1", 64'(qaddr_o), 64'h0_0077_7000);
        wr(5'd14, 2'd1, 32'd2);
        rd(5'd8, 2'd2, 32'h0001_2345, "R5 frame q2 kept");

        // R7 size table
        wr(5'd14, 2'd1, 32'd0);
        rd(5'd12, 2'd1, 32'd64, "R7 size q0");
        wr(5'd14, 2'd1, 32'd3);
        rd(5'd12, 2'd1, 32'd256, "R7 size q3");
        wr(5'd14, 2'd1, 32'd1);
        rd(5'd12, 2'd2, 32'd128, "R7 size q1");

        // R8 doorbell
        wr(5'd16, 2'd1, 32'd3);
        idle();
        chk("R8 kick high", 64'(kick_o), 64'd1);
        chk("R8 kick index", 64'(kick_idx_o), 64'd3);
        idle();
        chk("R8 kick one cycle", 64'(kick_o), 64'd0);
        rd(5'd16, 2'd2, 32'hFFFF_FFFF, "R8 doorbell reads ones");

        // R9 unmapped
        rd(5'd2,  2'd0, 32'h0000_00FF, "R9 unmapped byte");
        rd(5'd20, 2'd2, 32'hFFFF_FFFF, "R9 unmapped word");
        rd(5'd1,  2'd1, 32'h0000_FFFF, "R9 unmapped half");

        // R10 cause register
        op(1'b0, 1'b0, 5'd0, 2'd0, 32'd0, 8'h05);
        idle();
        chk("R10 irq raised", 64'(irq_o), 64'd1);
        rd(5'd19, 2'd0, 32'h05, "R10 cause read");
        idle();
        chk("R10 irq dropped", 64'(irq_o), 64'd0);
        op(1'b0, 1'b0, 5'd0, 2'd0, 32'd0, 8'h01);
        rd(5'd19, 2'd0, 32'h01, "R10 read with set", 8'h02);
        idle();
        chk("R10 irq after set and read", 64'(irq_o), 64'd0);
        rd(5'd19, 2'd0, 32'h02, "R10 set survives clear");
        op(1'b0, 1'b0, 5'd0, 2'd0, 32'd0, 8'h05);

        // R11 status and device reset
        wr(5'd18, 2'd2, 32'h0000_01FF);
        idle();
        chk("R11 status out", 64'(dev_status_o), 64'hFF);
        rd(5'd18, 2'd0, 32'hFF, "R11 status read");
        wr(5'd4, 2'd2, 32'h0000_DEAD);
        wr(5'd14, 2'd1, 32'd2);
        chk("R11 irq before reset", 64'(irq_o), 64'd1);
        wr(5'd18, 2'd0, 32'h0000_0100);
        idle();
        chk("R11 irq after reset", 64'(irq_o), 64'd0);
        chk("R11 guest out after reset", 64'(guest_features_o), 64'd0);
        rd(5'd4,  2'd2, 32'h0, "R11 guest cleared");
        rd(5'd14, 2'd1, 32'h0, "R11 selector cleared");
        rd(5'd19, 2'd0, 32'h0, "R11 cause cleared");
        rd(5'd18, 2'd0, 32'h0, "R11 status zero");
        wr(5'd14, 2'd1, 32'd2);
        rd(5'd8, 2'd2, 32'h0, "R11 frame q2 cleared");
        wr(5'd14, 2'd1, 32'd1);
        rd(5'd8, 2'd2, 32'h0, "R11 frame q1 cleared");

        idle();
        idle();
        idle();
        if (exp_data.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_data.size());
        end
        finish_run();
    end

endmodule